// File: doc/BRIEF.md
# Memory Configuration Register Bank

This block holds the bus configuration word of a burst memory device, plus a raw companion refresh configuration word and a read-only identification word. Software reaches these registers over a 16-bit multiplexed address/data bus while a control-register-enable input is high. A two-bit register select picks the target. The select corresponds to address bits [19:18] of the device.

A register write opens when the enable is high and the address-valid, chip-select and write-enable strobes (all active low) are low together. The block keeps the bus value from the last cycle in which all three were low. It commits that value when the first of the three strobes rises. Before a value reaches the bus configuration register, it is checked against the legal latency, burst and reserved-bit encodings. A value that fails any of these checks loads the complete default word, 16'h9D1F, in its place. The stored word is decoded into plain configuration outputs that the burst engine uses.

A register read drives the selected word onto the data lines. The lines stay at zero when no read is enabled. No valid/ready handshake exists on this interface: the strobes themselves frame each transfer, and the block never applies back-pressure, because a commit always completes in one clock.

Top module: `mem_cfg_regbank`

## Requirements
- R1: After reset the bus configuration word is 16'h9D1F and the refresh word equals the RCR_RESET parameter.
- R2: A write opens when cre=1 and adv_n, cs_n and we_n are all 0. It commits the bus value held in the last cycle in which all three were low. The commit happens at the clock edge that first samples any one of the three strobes high, and the new contents are visible after that edge.
- R3: A write commits only once. Strobe rises that follow the first rise do not write again, and neither do data changes after it. Strobe activity while cre=0 writes nothing.
- R4: Select code 2'b10 targets the bus configuration word, 2'b00 the refresh word, 2'b01 the ID word and 2'b11 nothing. Writes with 2'b01 or 2'b11 change no register.
- R5: If the latency code in bits [13:11] is outside 3'b010..3'b110, the whole bus configuration word becomes 16'h9D1F.
- R6: If the burst code in bits [2:0] is not one of 3'b001, 3'b010, 3'b011, 3'b100 or 3'b111, the whole word becomes 16'h9D1F.
- R7: If any of the reserved bits 9, 7 or 6 is 1, the whole word becomes 16'h9D1F.
- R8: The decoded outputs follow the stored word. cfg_async comes from bit 15 (1=asynchronous), cfg_fixed_latency from bit 14, cfg_wait_active_high from bit 10, cfg_wait_early from bit 8 (1=one clock early), cfg_drive_code from bits [5:4] (00 full, 01 half, 10 quarter, 11 eighth) and cfg_no_wrap from bit 3.
- R9: cfg_latency_clocks equals the latency code, which is 2..6 clocks. cfg_burst_words is 4, 8, 16 or 32 for burst codes 1..4. For code 3'b111, cfg_burst_continuous is 1 and cfg_burst_words is 0.
- R10: dq_oe is 1 only while cre=1, cs_n=0, oe_n=0, we_n=1 and adv_n=1. While dq_oe is 1, dq_out carries the selected word: the ID word reads as DEVICE_ID and select 2'b11 reads as zero. At all other times dq_out is 0.
- R11: The refresh word stores all 16 written bits without any check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cre | input | 1 | Control-register-enable |
| adv_n | input | 1 | Address-valid strobe, active low |
| cs_n | input | 1 | Chip-select strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| oe_n | input | 1 | Output-enable, active low |
| reg_sel | input | 2 | Register select (address bits [19:18]) |
| dq_in | input | 16 | Bus value being written |
| dq_out | output | 16 | Read-back data |
| dq_oe | output | 1 | Read-back drive enable |
| cfg_async | output | 1 | Asynchronous operating mode |
| cfg_fixed_latency | output | 1 | Fixed initial latency |
| cfg_latency_clocks | output | 3 | Latency in clocks |
| cfg_wait_active_high | output | 1 | Wait signal polarity |
| cfg_wait_early | output | 1 | Wait asserted one clock before data |
| cfg_drive_code | output | 2 | Drive strength code |
| cfg_no_wrap | output | 1 | Burst does not wrap |
| cfg_burst_words | output | 6 | Burst length in words, 0 when continuous |
| cfg_burst_continuous | output | 1 | Continuous burst |

## Verification
The bench builds the block with DEVICE_ID=16'hA5C3 and RCR_RESET=16'h0B0B. These values differ from the default word and from each other, so a read that returns the wrong register, or a reset that loads the wrong word, shows up at the data lines. The tests commit writes through each of the three strobes. They include a case where the data changes after the first rise. They write every class of invalid code after a legal word, so a revert to 16'h9D1F can be seen.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  localparam int CFG_DATA_W = 16;
  localparam int CFG_SEL_W  = 2;
  localparam int CFG_WORDS_W = 6;
  localparam logic [CFG_DATA_W-1:0] BCR_DEFAULT = 16'h9D1F;

  typedef enum logic [CFG_SEL_W-1:0] {
    SEL_RCR  = 2'b00,
    SEL_DID  = 2'b01,
    SEL_BCR  = 2'b10,
    SEL_NONE = 2'b11
  } regsel_e;

  typedef struct packed {
    logic       async_mode;
    logic       fixed_lat;
    logic [2:0] lat_clocks;
    logic       wait_hi;
    logic       wait_early;
    logic [1:0] drive;
    logic       no_wrap;
    logic [CFG_WORDS_W-1:0] burst_words;
    logic       burst_cont;
  } cfg_view_t;

  function automatic logic lat_code_ok(input logic [2:0] c);
    return (c >= 3'd2) && (c <= 3'd6);
  endfunction

  function automatic logic burst_code_ok(input logic [2:0] c);
    return (c inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd7});
  endfunction
endpackage

// File: rtl/cfg_strobe_track.sv
module cfg_strobe_track #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cre,
  input  logic              adv_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic [DATA_W-1:0] dq_in,
  output logic              commit,
  output logic [SEL_W-1:0]  cap_sel,
  output logic [DATA_W-1:0] cap_data
);
  logic armed_q;
  logic open_now;

  // all strobes low with the enable high: write phase, keep refreshing the capture
  assign open_now = cre & ~adv_n & ~cs_n & ~we_n;
  // armed means all three were low last edge, so any high now is the first rise
  assign commit   = armed_q & (adv_n | cs_n | we_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      cap_sel  <= '0;
      cap_data <= '0;
    end else if (open_now) begin
      armed_q  <= 1'b1;
      cap_sel  <= sel_in;
      cap_data <= dq_in;
    end else if (commit) begin
      armed_q  <= 1'b0;
    end
  end

  // R3: one commit per write phase
  p_single_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/cfg_field_check.sv
module cfg_field_check
  import cfgreg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] cand,
  output logic              legal,
  output logic [DATA_W-1:0] checked
);
  logic lat_ok, burst_ok, rsv_ok;

  always_comb begin
    lat_ok   = lat_code_ok(cand[13:11]);
    burst_ok = burst_code_ok(cand[2:0]);
    rsv_ok   = ~(cand[9] | cand[7] | cand[6]);
    legal    = lat_ok & burst_ok & rsv_ok;
    checked  = legal ? cand : BCR_DEFAULT;
  end
endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode
  import cfgreg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] word,
  output cfg_view_t         view
);
  always_comb begin
    view.async_mode = word[15];
    view.fixed_lat  = word[14];
    view.lat_clocks = word[13:11];
    view.wait_hi    = word[10];
    view.wait_early = word[8];
    view.drive      = word[5:4];
    view.no_wrap    = word[3];
    view.burst_cont = (word[2:0] == 3'd7);
    if (word[2:0] >= 3'd1 && word[2:0] <= 3'd4)
      view.burst_words = CFG_WORDS_W'(6'd2 << word[2:0]);
    else
      view.burst_words = '0;
  end
endmodule

// File: rtl/cfg_readback.sv
module cfg_readback #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2,
  parameter logic [DATA_W-1:0] DEV_ID = '0
) (
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] rcr_word,
  input  logic [DATA_W-1:0] bcr_word,
  output logic [DATA_W-1:0] dq_out
);
  localparam int NUM_SLOTS = 1 << SEL_W;
  logic [DATA_W-1:0] slot [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (i == int'(cfgreg_pkg::SEL_RCR)) begin : g_rcr
      assign slot[i] = rcr_word;
    end else if (i == int'(cfgreg_pkg::SEL_BCR)) begin : g_bcr
      assign slot[i] = bcr_word;
    end else if (i == int'(cfgreg_pkg::SEL_DID)) begin : g_did
      assign slot[i] = DEV_ID;
    end else begin : g_none
      assign slot[i] = '0;
    end
  end

  assign dq_out = rd_en ? slot[sel] : '0;
endmodule

// File: rtl/mem_cfg_regbank.sv
module mem_cfg_regbank
  import cfgreg_pkg::*;
#(
  parameter logic [15:0] DEVICE_ID = 16'h0001,
  parameter logic [15:0] RCR_RESET = 16'h0010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cre,
  input  logic        adv_n,
  input  logic        cs_n,
  input  logic        we_n,
  input  logic        oe_n,
  input  logic [1:0]  reg_sel,
  input  logic [15:0] dq_in,
  output logic [15:0] dq_out,
  output logic        dq_oe,
  output logic        cfg_async,
  output logic        cfg_fixed_latency,
  output logic [2:0]  cfg_latency_clocks,
  output logic        cfg_wait_active_high,
  output logic        cfg_wait_early,
  output logic [1:0]  cfg_drive_code,
  output logic        cfg_no_wrap,
  output logic [5:0]  cfg_burst_words,
  output logic        cfg_burst_continuous
);
  localparam int DW = CFG_DATA_W;
  localparam int SW = CFG_SEL_W;

  logic          commit;
  logic [SW-1:0] cap_sel;
  logic [DW-1:0] cap_data;
  logic          cap_legal;
  logic [DW-1:0] cap_checked;
  logic [DW-1:0] bcr_q, rcr_q;
  cfg_view_t     view;

  cfg_strobe_track #(.DATA_W(DW), .SEL_W(SW)) u_track (
    .clk(clk), .rst_n(rst_n), .cre(cre), .adv_n(adv_n), .cs_n(cs_n),
    .we_n(we_n), .sel_in(reg_sel), .dq_in(dq_in),
    .commit(commit), .cap_sel(cap_sel), .cap_data(cap_data)
  );

  cfg_field_check #(.DATA_W(DW)) u_check (
    .cand(cap_data), .legal(cap_legal), .checked(cap_checked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcr_q <= BCR_DEFAULT;
      rcr_q <= RCR_RESET;
    end else if (commit) begin
      case (regsel_e'(cap_sel))
        SEL_BCR: bcr_q <= cap_checked;
        SEL_RCR: rcr_q <= cap_data;
        default: ;
      endcase
    end
  end

  cfg_field_decode #(.DATA_W(DW)) u_decode (.word(bcr_q), .view(view));

  assign cfg_async            = view.async_mode;
  assign cfg_fixed_latency    = view.fixed_lat;
  assign cfg_latency_clocks   = view.lat_clocks;
  assign cfg_wait_active_high = view.wait_hi;
  assign cfg_wait_early       = view.wait_early;
  assign cfg_drive_code       = view.drive;
  assign cfg_no_wrap          = view.no_wrap;
  assign cfg_burst_words      = view.burst_words;
  assign cfg_burst_continuous = view.burst_cont;

  assign dq_oe = cre & ~cs_n & ~oe_n & we_n & adv_n;

  cfg_readback #(.DATA_W(DW), .SEL_W(SW), .DEV_ID(DEVICE_ID)) u_rb (
    .rd_en(dq_oe), .sel(reg_sel), .rcr_word(rcr_q), .bcr_word(bcr_q),
    .dq_out(dq_out)
  );

  // R2: registers move only on the edge after a commit
  p_hold_without_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(bcr_q) && $stable(rcr_q)));
  // R4: commits aimed at the ID slot leave both stores alone
  p_id_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cap_sel == SEL_DID) |=> ($stable(bcr_q) && $stable(rcr_q)));
  // R5: stored latency code is always legal
  p_latency_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latency_clocks >= 3'd2 && cfg_latency_clocks <= 3'd6));
  // R6: stored burst code is always legal
  p_burst_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_burst_continuous || cfg_burst_words != 6'd0));
  // R7: reserved bits never stored as one
  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bcr_q[9] == 1'b0 && bcr_q[7] == 1'b0 && bcr_q[6] == 1'b0));
  // R10: bus quiet unless a read is enabled
  p_bus_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == 16'h0000));
endmodule

// File: tb/tb_mem_cfg_regbank.sv
module tb_mem_cfg_regbank;
  localparam logic [15:0] DEV = 16'hA5C3;
  localparam logic [15:0] RCR0 = 16'h0B0B;
  localparam logic [15:0] DEF = 16'h9D1F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cre = 1'b0, adv_n = 1'b1, cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0] reg_sel = 2'b00;
  logic [15:0] dq_in = 16'h0000;
  logic [15:0] dq_out;
  logic dq_oe;
  logic cfg_async, cfg_fixed_latency, cfg_wait_active_high, cfg_wait_early;
  logic cfg_no_wrap, cfg_burst_continuous;
  logic [2:0] cfg_latency_clocks;
  logic [1:0] cfg_drive_code;
  logic [5:0] cfg_burst_words;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] bcr_m, rcr_m;

  logic [31:0] exp_q[$];
  int kind_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  mem_cfg_regbank #(.DEVICE_ID(DEV), .RCR_RESET(RCR0)) dut (
    .clk(clk), .rst_n(rst_n), .cre(cre), .adv_n(adv_n), .cs_n(cs_n),
    .we_n(we_n), .oe_n(oe_n), .reg_sel(reg_sel), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .cfg_async(cfg_async),
    .cfg_fixed_latency(cfg_fixed_latency), .cfg_latency_clocks(cfg_latency_clocks),
    .cfg_wait_active_high(cfg_wait_active_high), .cfg_wait_early(cfg_wait_early),
    .cfg_drive_code(cfg_drive_code), .cfg_no_wrap(cfg_no_wrap),
    .cfg_burst_words(cfg_burst_words), .cfg_burst_continuous(cfg_burst_continuous)
  );

  function automatic logic [15:0] accept(input logic [15:0] v);
    logic ok;
    ok = (v[13:11] inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd6}) &&
         (v[2:0] inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd7}) &&
         !v[9] && !v[7] && !v[6];
    return ok ? v : DEF;
  endfunction

  function automatic logic [31:0] view_of(input logic [15:0] v);
    logic [5:0] w;
    case (v[2:0])
      3'd1: w = 6'd4;
      3'd2: w = 6'd8;
      3'd3: w = 6'd16;
      3'd4: w = 6'd32;
      default: w = 6'd0;
    endcase
    return {15'd0, v[15], v[14], v[13:11], v[10], v[8], v[5:4], v[3], w, (v[2:0] == 3'd7)};
  endfunction

  function automatic logic [31:0] view_dut();
    return {15'd0, cfg_async, cfg_fixed_latency, cfg_latency_clocks, cfg_wait_active_high,
            cfg_wait_early, cfg_drive_code, cfg_no_wrap, cfg_burst_words, cfg_burst_continuous};
  endfunction

  // monitor: pops expected items and compares a little after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (kind_q.size() != 0) begin
        logic [31:0] e, a;
        int k;
        string t;
        e = exp_q.pop_front();
        k = kind_q.pop_front();
        t = tag_q.pop_front();
        a = (k == 0) ? {15'd0, dq_oe, dq_out} : view_dut();
        n_cmp++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: got %h exp %h", t, a, e);
        end
      end
    end
  end

  task automatic push(input int k, input logic [31:0] e, input string t);
    kind_q.push_back(k);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic idle();
    cre = 1'b0; adv_n = 1'b1; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  // strobe: 0 address-valid, 1 chip-select, 2 write-enable rises first
  task automatic wr(input logic [1:0] s, input logic [15:0] v, input int strobe, input logic en);
    @(negedge clk);
    cre = en; cs_n = 1'b0; we_n = 1'b0; adv_n = 1'b0; oe_n = 1'b1;
    reg_sel = s; dq_in = v;
    @(negedge clk);
    if (strobe == 0) adv_n = 1'b1;
    else if (strobe == 1) cs_n = 1'b1;
    else we_n = 1'b1;
    @(negedge clk);
    idle();
    if (en) begin
      if (s == 2'b10) bcr_m = accept(v);
      else if (s == 2'b00) rcr_m = v;
    end
  endtask

  task automatic rd(input logic [1:0] s, input logic [15:0] e, input string t);
    @(negedge clk);
    cre = 1'b1; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; adv_n = 1'b1; reg_sel = s;
    push(0, {15'd0, 1'b1, e}, t);
    @(negedge clk);
    idle();
    push(0, 32'd0, "R10 idle bus");
  endtask

  task automatic chk_view(input string t);
    push(1, view_of(bcr_m), t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bcr_m = DEF; rcr_m = RCR0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_view("R1 R8 R9 reset view");
    rd(2'b10, DEF, "R1 reset bcr");
    rd(2'b00, RCR0, "R1 reset rcr");

    // R2 commit via write-enable, R8 R9 decode
    wr(2'b10, 16'h6822, 2, 1'b1);
    chk_view("R2 R8 commit via we");
    rd(2'b10, 16'h6822, "R2 readback");
    // R2 commit via chip-select
    wr(2'b10, 16'h9539, 1, 1'b1);
    chk_view("R2 R9 commit via cs, 4 words");

    // R2 R3 commit via address-valid, later data and rises ignored
    @(negedge clk);
    cre = 1'b1; cs_n = 1'b0; we_n = 1'b0; adv_n = 1'b0; reg_sel = 2'b10; dq_in = 16'h3004;
    @(negedge clk);
    adv_n = 1'b1; dq_in = 16'h6822;
    @(negedge clk);
    we_n = 1'b1; dq_in = 16'h1005;
    @(negedge clk);
    idle();
    bcr_m = 16'h3004;
    chk_view("R3 first rise only, 32 words");
    // R2 value from last all-low cycle
    @(negedge clk);
    cre = 1'b1; cs_n = 1'b0; we_n = 1'b0; adv_n = 1'b0; reg_sel = 2'b10; dq_in = 16'h6822;
    @(negedge clk);
    dq_in = 16'h2007;
    @(negedge clk);
    cs_n = 1'b1; dq_in = 16'h9539;
    @(negedge clk);
    idle();
    bcr_m = 16'h2007;
    chk_view("R2 R9 last all-low value, continuous");

    // R5 invalid latency codes
    wr(2'b10, 16'h0001, 2, 1'b1);
    rd(2'b10, DEF, "R5 latency 000 reverts");
    wr(2'b10, 16'h6822, 2, 1'b1);
    wr(2'b10, 16'h3801, 2, 1'b1);
    rd(2'b10, DEF, "R5 latency 111 reverts");
    // R6 invalid burst codes
    wr(2'b10, 16'h6822, 2, 1'b1);
    wr(2'b10, 16'h1000, 0, 1'b1);
    rd(2'b10, DEF, "R6 burst 000 reverts");
    wr(2'b10, 16'h6822, 2, 1'b1);
    wr(2'b10, 16'h1005, 1, 1'b1);
    chk_view("R6 burst 101 reverts");
    wr(2'b10, 16'h6822, 2, 1'b1);
    wr(2'b10, 16'h1006, 2, 1'b1);
    rd(2'b10, DEF, "R6 burst 110 reverts");
    // R7 reserved bits
    wr(2'b10, 16'h6822, 2, 1'b1);
    wr(2'b10, 16'h1201, 2, 1'b1);
    rd(2'b10, DEF, "R7 bit9 reverts");
    wr(2'b10, 16'h6822, 2, 1'b1);
    wr(2'b10, 16'h1041, 2, 1'b1);
    rd(2'b10, DEF, "R7 bit6 reverts");
    wr(2'b10, 16'h6822, 2, 1'b1);
    wr(2'b10, 16'h1081, 2, 1'b1);
    rd(2'b10, DEF, "R7 bit7 reverts");

    // R3 enable low ignored
    wr(2'b10, 16'h6822, 2, 1'b1);
    wr(2'b10, 16'h9539, 2, 1'b0);
    rd(2'b10, 16'h6822, "R3 cre low ignored");

    // R11 refresh word raw
    wr(2'b00, 16'hFFFF, 2, 1'b1);
    rd(2'b00, 16'hFFFF, "R11 rcr all ones");
    rd(2'b10, 16'h6822, "R4 rcr write leaves bcr");

    // R4 ID and unused selects ignored
    wr(2'b01, 16'h1234, 2, 1'b1);
    wr(2'b11, 16'h9539, 0, 1'b1);
    rd(2'b10, 16'h6822, "R4 bcr unchanged");
    rd(2'b00, 16'hFFFF, "R4 rcr unchanged");
    rd(2'b01, DEV, "R4 R10 device id");
    rd(2'b11, 16'h0000, "R10 unused select reads zero");

    // R10 no drive without read conditions
    @(negedge clk);
    cre = 1'b1; cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; adv_n = 1'b1; reg_sel = 2'b10;
    push(0, 32'd0, "R10 oe high no drive");
    @(negedge clk);
    oe_n = 1'b0; adv_n = 1'b0;
    push(0, 32'd0, "R10 adv low no drive");
    @(negedge clk);
    adv_n = 1'b1; cre = 1'b0;
    push(0, 32'd0, "R10 cre low no drive");
    @(negedge clk);
    idle();
    chk_view("R8 final view");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule